// File: doc/BRIEF.md
# I2C Receive Byte Queue with Fill Threshold

This block sits between the bit engine of an I2C controller and the register port that software reads. Each byte the engine has received is pushed into a 32-entry first-in first-out store. Software pops bytes from the other side, and the block reports how many bytes are held. Software programs a fill level. When the queue reaches that level, the block raises a sticky threshold status and asks the bit engine to hold SCL low before it starts the next byte. A pop that lowers the fill below the level withdraws that request, so reception carries on.

For a read group that ends the transaction, software arms a one-shot end-of-group flag. While the flag is armed and one more byte would reach the threshold, the block tells the bit engine to answer that next byte with NACK instead of ACK. The flag clears itself once that byte is stored. A single flush command empties the queue at once. A sticky full flag and a sticky overflow flag complete the status.

The threshold tracker is a four-state machine, updated from the next-cycle fill count and the programmed level. The states are TS_OFF (level programmed as 0), TS_BELOW (fill under the level), TS_AT (fill equal to the level) and TS_ABOVE (fill over the level). Any state moves to TS_OFF when the level is 0. Otherwise it moves to TS_BELOW, TS_AT or TS_ABOVE by comparing the next fill with the level. The threshold status is set only on the TS_BELOW to TS_AT transition. The stall request is asserted in TS_AT.

Top module: `i2c_rxq`

## Requirements
- R1: After reset the fill count, every status flag, the stall request, the NACK request and the pop data are all 0. The fill count never exceeds 32 and is reported on a 6-bit output.
- R2: Bytes come out in the order they were pushed. `pop_data` shows the oldest byte while the queue is not empty and 0x00 while it is empty. A pop on an empty queue leaves the fill count at 0.
- R3: `thst` sets on the clock edge where the fill count becomes equal to a nonzero `thr_level` after having been below it. It stays set until a `thst_clr` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R4: `stall_req` is high exactly while the fill count equals the nonzero level. A pop that takes the fill below the level drops `stall_req` in the cycle after that pop.
- R5: With `thr_level` equal to 0, neither `thst` nor `stall_req` is ever raised.
- R6: A `last_set` pulse sets `last_flag`. `nack_next` is high while `last_flag` is set and the fill count plus one equals the nonzero level.
- R7: `last_flag` clears once a byte is stored while `nack_next` is high.
- R8: `full_flag` sets when the fill count reaches 32 from below. A `full_clr` pulse clears it, and a set wins over a clear in the same cycle.
- R9: A push to a full queue with no pop in the same cycle is dropped and sets the sticky `ovf_flag`. A push and a pop together on a full queue are both accepted, and the fill count stays at 32.
- R10: `fifo_clear` empties the queue in one cycle and clears `ovf_flag` and `last_flag`. It overrides any push or pop in the same cycle.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full leave the fill count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Bit engine stores a received byte |
| push_data | input | 8 | Received byte |
| pop_req | input | 1 | Software removes the oldest byte |
| pop_data | output | 8 | Oldest byte, or 0x00 when empty |
| thr_level | input | 6 | Programmed fill level; 0 disables the threshold |
| last_set | input | 1 | Arms the end-of-group NACK flag |
| fifo_clear | input | 1 | Flushes the queue |
| thst_clr | input | 1 | Write-one clear of the threshold status |
| full_clr | input | 1 | Write-one clear of the full status |
| level | output | 6 | Current fill count, 0 to 32 |
| thst | output | 1 | Sticky threshold-reached status |
| stall_req | output | 1 | Request to hold SCL low before the next byte |
| last_flag | output | 1 | End-of-group flag is armed |
| nack_next | output | 1 | Answer the next received byte with NACK |
| full_flag | output | 1 | Sticky queue-full status |
| ovf_flag | output | 1 | Sticky dropped-push status |

## Verification
The bench makes pairs of events fall on the same clock edge and checks which effect the block keeps. A push that completes the threshold is driven together with a `thst_clr` pulse, and the status must read as set in the next cycle. A push is paired with a pop on a half-filled queue and again on a full queue. In both cases the fill count must not move, and the scoreboard must see the popped byte in order with the new byte kept behind it. A flush is driven together with a push, and the fill, the overflow flag and the pop data must all read 0 in the next cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        TS_OFF   = 2'd0,
        TS_BELOW = 2'd1,
        TS_AT    = 2'd2,
        TS_ABOVE = 2'd3
    } thr_state_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [DW-1:0]    wr_data,
    input  logic             pop_req,
    input  logic             flush,
    output logic             push_ok,
    output logic             push_drop,
    output logic [DW-1:0]    head_data,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop_ok;

    assign pop_ok    = pop_req && !flush && (count != '0);
    assign push_ok   = push_valid && !flush && ((count != FULL_CNT) || pop_ok);
    assign push_drop = push_valid && !flush && !push_ok;
    assign head_data = (count != '0) ? mem[rd_ptr] : '0;

    always_comb begin
        if (flush)
            cnt_nxt = '0;
        else if (push_ok && !pop_ok)
            cnt_nxt = count + CNT_W'(1);
        else if (pop_ok && !push_ok)
            cnt_nxt = count - CNT_W'(1);
        else
            cnt_nxt = count;
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= cnt_nxt;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok)
                    wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
                if (pop_ok)
                    rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
            end
        end
    end
endmodule

// File: rtl/rxq_thr_ctl.sv
module rxq_thr_ctl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] thr,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             push_ok,
    input  logic             push_drop,
    input  logic             flush,
    input  logic             thst_clr,
    input  logic             full_clr,
    input  logic             last_set,
    output logic             thst,
    output logic             stall_req,
    output logic             last_flag,
    output logic             nack_next,
    output logic             full_flag,
    output logic             ovf_flag
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    thr_state_e state, state_nxt;
    logic       thst_set;
    logic       full_set;

    // next state from the next-cycle fill against the level
    always_comb begin
        if (thr == '0)
            state_nxt = TS_OFF;
        else if (cnt_nxt < thr)
            state_nxt = TS_BELOW;
        else if (cnt_nxt == thr)
            state_nxt = TS_AT;
        else
            state_nxt = TS_ABOVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= TS_OFF;
        else
            state <= state_nxt;
    end

    // outputs of the tracker
    always_comb begin
        stall_req = 1'b0;
        thst_set  = 1'b0;
        unique case (state)
            TS_OFF:   ;
            TS_BELOW: thst_set  = (state_nxt == TS_AT);
            TS_AT:    stall_req = 1'b1;
            TS_ABOVE: ;
        endcase
        nack_next = last_flag && (thr != '0) && ((count + CNT_W'(1)) == thr);
    end

    assign full_set = (cnt_nxt == FULL_CNT) && (count != FULL_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thst      <= 1'b0;
            full_flag <= 1'b0;
            ovf_flag  <= 1'b0;
            last_flag <= 1'b0;
        end else begin
            if (thst_set)
                thst <= 1'b1;
            else if (thst_clr)
                thst <= 1'b0;

            if (full_set)
                full_flag <= 1'b1;
            else if (full_clr)
                full_flag <= 1'b0;

            if (flush)
                ovf_flag <= 1'b0;
            else if (push_drop)
                ovf_flag <= 1'b1;

            if (flush)
                last_flag <= 1'b0;
            else if (last_set)
                last_flag <= 1'b1;
            else if (push_ok && nack_next)
                last_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_rxq.sv
module i2c_rxq #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_valid,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop_req,
    output logic [DW-1:0]                pop_data,
    input  logic [$clog2(DEPTH+1)-1:0]   thr_level,
    input  logic                         last_set,
    input  logic                         fifo_clear,
    input  logic                         thst_clr,
    input  logic                         full_clr,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         thst,
    output logic                         stall_req,
    output logic                         last_flag,
    output logic                         nack_next,
    output logic                         full_flag,
    output logic                         ovf_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push_ok;
    logic             push_drop;
    logic [CNT_W-1:0] cnt_nxt;

    rxq_store #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .wr_data    (push_data),
        .pop_req    (pop_req),
        .flush      (fifo_clear),
        .push_ok    (push_ok),
        .push_drop  (push_drop),
        .head_data  (pop_data),
        .count      (level),
        .cnt_nxt    (cnt_nxt)
    );

    rxq_thr_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr       (thr_level),
        .count     (level),
        .cnt_nxt   (cnt_nxt),
        .push_ok   (push_ok),
        .push_drop (push_drop),
        .flush     (fifo_clear),
        .thst_clr  (thst_clr),
        .full_clr  (full_clr),
        .last_set  (last_set),
        .thst      (thst),
        .stall_req (stall_req),
        .last_flag (last_flag),
        .nack_next (nack_next),
        .full_flag (full_flag),
        .ovf_flag  (ovf_flag)
    );
endmodule

// File: rtl/i2c_rxq_chk.sv
module i2c_rxq_chk #(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             pop_req,
    input logic             fifo_clear,
    input logic             last_set,
    input logic [CNT_W-1:0] thr_level,
    input logic [CNT_W-1:0] level,
    input logic             thst,
    input logic             stall_req,
    input logic             last_flag,
    input logic             nack_next,
    input logic             ovf_flag
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_CNT); // R1

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_valid && !fifo_clear && level == '0) |=> (level == '0)); // R2

    AST_THST_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thst) |-> (level == $past(thr_level)) && ($past(thr_level) != '0)); // R3

    AST_STALL_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (level == $past(thr_level)) && ($past(thr_level) != '0)); // R4

    AST_NACK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        nack_next |-> last_flag); // R6

    AST_LAST_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_next && push_valid && !fifo_clear && !last_set) |=> !last_flag); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !pop_req && !fifo_clear && level == FULL_CNT)
        |=> (ovf_flag && level == FULL_CNT)); // R9

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> (level == '0 && !ovf_flag && !last_flag)); // R10
endmodule

bind i2c_rxq i2c_rxq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .fifo_clear (fifo_clear),
    .last_set   (last_set),
    .thr_level  (thr_level),
    .level      (level),
    .thst       (thst),
    .stall_req  (stall_req),
    .last_flag  (last_flag),
    .nack_next  (nack_next),
    .ovf_flag   (ovf_flag)
);

// File: tb/i2c_rxq_bench.sv
module i2c_rxq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic [5:0] thr_level = '0;
    logic       last_set = 1'b0;
    logic       fifo_clear = 1'b0;
    logic       thst_clr = 1'b0;
    logic       full_clr = 1'b0;
    logic [5:0] level;
    logic       thst, stall_req, last_flag, nack_next, full_flag, ovf_flag;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    i2c_rxq u_i2c_rxq (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .thr_level(thr_level),
        .last_set(last_set), .fifo_clear(fifo_clear), .thst_clr(thst_clr),
        .full_clr(full_clr), .level(level), .thst(thst), .stall_req(stall_req),
        .last_flag(last_flag), .nack_next(nack_next), .full_flag(full_flag),
        .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares popped bytes with the scoreboard (R2)
    always @(posedge clk) begin
        if (rst_n && pop_req && !fifo_clear) begin
            if (exp_q.size() > 0)
                chk("R2 pop order", {24'b0, pop_data}, {24'b0, exp_q.pop_front()});
            else
                chk("R2 empty pop data", {24'b0, pop_data}, 32'h0);
        end
    end

    task automatic tick;
        @(negedge clk);
        push_valid = 1'b0; pop_req = 1'b0; last_set = 1'b0;
        fifo_clear = 1'b0; thst_clr = 1'b0; full_clr = 1'b0;
    endtask

    // driver: one push, optionally with a pop; records expected bytes
    task automatic push_b(input logic [7:0] d, input bit accept, input bit with_pop);
        push_valid = 1'b1; push_data = d; pop_req = with_pop;
        if (accept) exp_q.push_back(d);
        tick();
    endtask

    task automatic pop_b;
        pop_req = 1'b1;
        tick();
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 level", {26'b0, level}, 0);
        chk("R1 flags", {26'b0, thst, stall_req, last_flag, nack_next, full_flag, ovf_flag}, 0);
        chk("R1 pop data", {24'b0, pop_data}, 0);

        thr_level = 6'd4;
        tick();
        push_b(8'h11, 1, 0); push_b(8'h22, 1, 0); push_b(8'h33, 1, 0);
        chk("R3 below level", {31'b0, thst}, 0);
        chk("R4 no stall below", {31'b0, stall_req}, 0);
        chk("R6 nack idle", {31'b0, nack_next}, 0);

        last_set = 1'b1; tick();
        chk("R6 last armed", {31'b0, last_flag}, 1);
        chk("R6 nack_next", {31'b0, nack_next}, 1);

        push_b(8'h44, 1, 0);
        chk("R3 level 4", {26'b0, level}, 4);
        chk("R3 thst set", {31'b0, thst}, 1);
        chk("R4 stall at level", {31'b0, stall_req}, 1);
        chk("R7 last consumed", {31'b0, last_flag}, 0);
        chk("R7 nack off", {31'b0, nack_next}, 0);

        thst_clr = 1'b1; tick();
        chk("R3 thst cleared", {31'b0, thst}, 0);
        chk("R4 stall held", {31'b0, stall_req}, 1);

        pop_b();
        chk("R4 level 3", {26'b0, level}, 3);
        chk("R4 stall released", {31'b0, stall_req}, 0);

        thst_clr = 1'b1;
        push_b(8'h55, 1, 0);
        chk("R3 set wins over clear", {31'b0, thst}, 1);

        push_b(8'h66, 1, 1);
        chk("R11 push+pop level", {26'b0, level}, 4);

        repeat (4) pop_b();
        chk("R2 drained", {26'b0, level}, 0);
        pop_b();
        chk("R2 empty pop level", {26'b0, level}, 0);

        thr_level = 6'd0; thst_clr = 1'b1; tick();
        for (int i = 0; i < 5; i++) push_b(8'(8'hB0 + i), 1, 0);
        chk("R5 thst off", {31'b0, thst}, 0);
        chk("R5 stall off", {31'b0, stall_req}, 0);
        chk("R5 level", {26'b0, level}, 5);

        thr_level = 6'd32; tick();
        for (int i = 0; i < 27; i++) push_b(8'(8'hC0 + i), 1, 0);
        chk("R8 level full", {26'b0, level}, 32);
        chk("R8 full flag", {31'b0, full_flag}, 1);
        chk("R3 thst at 32", {31'b0, thst}, 1);
        chk("R4 stall at 32", {31'b0, stall_req}, 1);

        push_b(8'hEE, 0, 0);
        chk("R9 dropped level", {26'b0, level}, 32);
        chk("R9 ovf set", {31'b0, ovf_flag}, 1);

        push_b(8'hA0, 1, 1);
        chk("R9 push+pop at full", {26'b0, level}, 32);

        full_clr = 1'b1; tick();
        chk("R8 full cleared", {31'b0, full_flag}, 0);

        last_set = 1'b1; tick();
        chk("R10 last armed", {31'b0, last_flag}, 1);
        fifo_clear = 1'b1; push_valid = 1'b1; push_data = 8'h99;
        exp_q.delete();
        tick();
        chk("R10 level 0", {26'b0, level}, 0);
        chk("R10 ovf cleared", {31'b0, ovf_flag}, 0);
        chk("R10 last cleared", {31'b0, last_flag}, 0);
        chk("R10 pop data 0", {24'b0, pop_data}, 0);

        push_b(8'h77, 1, 0);
        pop_b();
        chk("R2 after flush", {26'b0, level}, 0);

        tick();
        finish_run();
    end
endmodule